// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a down-counting interval timer with automatic reload. A counter steps down by one on every cycle in which the tick-enable input is high and the run bit is set. When the counter is already at zero and another tick arrives, the counter does not wrap. It copies in the value of a separate reload register. A reload value R therefore produces one underflow every R+1 ticks, so the division ratio can be anything from 1 to 65536 with the default 16-bit width.

Each underflow can invert a waveform output, which gives a square wave or a pulse-width-modulated signal. Each underflow also sets a sticky pending flag, and that flag drives an interrupt request through an enable bit.

A processor programs the timer through a plain byte-wide register port. The port has a write strobe, an address, write data and combinational read data. It has no handshake: every write strobe is accepted in the cycle it is presented, so no back-pressure exists. The counter and the reload register are each reached as byte lanes.

Top module: `tmr_autoreload`

## Requirements
- R1: After reset, the counter, the reload register, every control bit, the pending flag, `tmr_out` and `irq` are all 0.
- R2: When the run bit (control bit 4) is 1 and `tick` is 1, a nonzero counter decreases by one at the clock edge. When `tick` is 0, the counter keeps its value.
- R3: When a tick arrives while running and the counter is 0, the counter loads the reload register's value at that edge, so reload value R gives an underflow every R+1 ticks. R = 0 gives an underflow on every tick, and R = 0xFFFF gives a 65536-tick period.
- R4: While the run bit is 0, the counter keeps its value whatever `tick` does.
- R5: With the toggle-enable bit (control bit 5) set, `tmr_out` inverts at every underflow edge. With the bit clear, underflows leave `tmr_out` unchanged.
- R6: The pending flag (control bit 7) is set by every underflow and stays set. Writing 1 to bit 7 of the control byte clears it, and writing 0 there leaves it alone. If an underflow and a clearing write fall in the same cycle, the flag stays set.
- R7: `irq` equals the pending flag ANDed with the interrupt-enable bit (control bit 6).
- R8: The byte map is as follows:
  - address 0 is the counter low byte and address 1 is the counter high byte;
  - address 2 is the reload low byte and address 3 is the reload high byte;
  - address 4 is the control byte, with bit 4 run, bit 5 toggle enable, bit 6 interrupt enable, bit 7 pending and bits 3..0 reading 0;
  - address 5 is the output level in bit 0, with the other bits reading 0;
  - every other address reads 0.

  Reads are combinational from the current state.
- R9: A write to a counter byte takes effect at that clock edge and replaces any decrement or reload in the same cycle. The other counter byte keeps its value, and that cycle produces no underflow.
- R10: A write to address 5 sets `tmr_out` to bit 0 of the written data at that edge. The write takes priority over an underflow toggle in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one pulse per timer step |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (3) | Register byte address |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data for `bus_addr`, combinational |
| tmr_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |

## Verification
Every state change lands at the clock edge that samples the stimulus. A write, a decrement, a reload, a toggle or a flag change driven before edge N is therefore visible at edge N. Reads add no latency, because `bus_rdata` is a combinational function of `bus_addr` and the registered state.

The driver applies inputs on the falling edge and pushes the expected `tmr_out` and `irq` for the coming rising edge into a queue. The monitor pops that entry on the following falling edge, exactly one edge later. Register read-backs are taken one nanosecond after an idle rising edge, once the combinational path has settled.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CTL_RUN  = 4;
  localparam int CTL_TOG  = 5;
  localparam int CTL_IE   = 6;
  localparam int CTL_PEND = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_RLD,
    SEL_CTL,
    SEL_OUT
  } tmr_sel_e;
endpackage

// File: rtl/tmr_addr_dec.sv
`timescale 1ns/1ps
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int NB = 2,
  parameter int AW = 3,
  localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [AW-1:0] addr,
  output tmr_sel_e      sel,
  output logic [LW-1:0] lane
);
  localparam int RLD_BASE = NB;
  localparam int CTL_ADDR = 2 * NB;
  localparam int OUT_ADDR = 2 * NB + 1;

  always_comb begin
    sel  = SEL_NONE;
    lane = '0;
    if (int'(addr) < RLD_BASE) begin
      sel  = SEL_CNT;
      lane = LW'(addr);
    end else if (int'(addr) < CTL_ADDR) begin
      sel  = SEL_RLD;
      lane = LW'(int'(addr) - RLD_BASE);
    end else if (int'(addr) == CTL_ADDR) begin
      sel = SEL_CTL;
    end else if (int'(addr) == OUT_ADDR) begin
      sel = SEL_OUT;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int NB = 2,
  parameter int DW = 8,
  localparam int LW = (NB > 1) ? $clog2(NB) : 1,
  localparam int CW = NB * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          we,
  input  tmr_sel_e      sel,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] rld_q,
  output logic          uflow
);
  logic          cnt_wr;
  logic          rld_wr;
  logic          step;
  logic [CW-1:0] cnt_d;

  assign cnt_wr = we && (sel == SEL_CNT);
  assign rld_wr = we && (sel == SEL_RLD);
  assign step   = tick && run && !cnt_wr;
  assign uflow  = step && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      cnt_d = (cnt_q == '0) ? rld_q : cnt_q - CW'(1);
    end
    for (int b = 0; b < NB; b++) begin
      if (cnt_wr && (lane == LW'(b))) begin
        cnt_d[b*DW +: DW] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar b = 0; b < NB; b++) begin : g_rld
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          byte_q <= '0;
      else if (rld_wr && lane == LW'(b))   byte_q <= wdata;
    end
    assign rld_q[b*DW +: DW] = byte_q;
  end
endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  tmr_sel_e      sel,
  input  logic [DW-1:0] wdata,
  input  logic          uflow,
  output logic          run_q,
  output logic          tog_q,
  output logic          ie_q,
  output logic          pend_q,
  output logic          out_q,
  output logic [DW-1:0] ctl_rd,
  output logic          irq
);
  logic ctl_wr;
  logic out_wr;

  assign ctl_wr = we && (sel == SEL_CTL);
  assign out_wr = we && (sel == SEL_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tog_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (ctl_wr) begin
      run_q <= wdata[CTL_RUN];
      tog_q <= wdata[CTL_TOG];
      ie_q  <= wdata[CTL_IE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pend_q <= 1'b0;
    else if (uflow)                      pend_q <= 1'b1;
    else if (ctl_wr && wdata[CTL_PEND])  pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              out_q <= 1'b0;
    else if (out_wr)         out_q <= wdata[0];
    else if (uflow && tog_q) out_q <= ~out_q;
  end

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[CTL_RUN]  = run_q;
    ctl_rd[CTL_TOG]  = tog_q;
    ctl_rd[CTL_IE]   = ie_q;
    ctl_rd[CTL_PEND] = pend_q;
  end

  assign irq = pend_q & ie_q;
endmodule

// File: rtl/tmr_autoreload.sv
`timescale 1ns/1ps
module tmr_autoreload
  import tmr_pkg::*;
#(
  parameter int NB = 2,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tmr_out,
  output logic          irq
);
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;
  localparam int CW = NB * DW;

  tmr_sel_e      sel;
  logic [LW-1:0] lane;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rld_q;
  logic          uflow;
  logic          run_q;
  logic          tog_q;
  logic          ie_q;
  logic          pend_q;
  logic [DW-1:0] ctl_rd;

  tmr_addr_dec #(.NB(NB), .AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .lane (lane)
  );

  tmr_counter #(.NB(NB), .DW(DW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .run   (run_q),
    .we    (bus_we),
    .sel   (sel),
    .lane  (lane),
    .wdata (bus_wdata),
    .cnt_q (cnt_q),
    .rld_q (rld_q),
    .uflow (uflow)
  );

  tmr_ctrl #(.DW(DW)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bus_we),
    .sel    (sel),
    .wdata  (bus_wdata),
    .uflow  (uflow),
    .run_q  (run_q),
    .tog_q  (tog_q),
    .ie_q   (ie_q),
    .pend_q (pend_q),
    .out_q  (tmr_out),
    .ctl_rd (ctl_rd),
    .irq    (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_CNT: bus_rdata = cnt_q[int'(lane)*DW +: DW];
      SEL_RLD: bus_rdata = rld_q[int'(lane)*DW +: DW];
      SEL_CTL: bus_rdata = ctl_rd;
      SEL_OUT: bus_rdata = DW'(tmr_out);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int NB = 2,
  parameter int DW = 8,
  parameter int AW = 3,
  localparam int CW = NB * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          wbit0,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rld,
  input logic          run,
  input logic          tog,
  input logic          pend,
  input logic          out,
  input logic          irq
);
  logic cnt_wr;
  logic out_wr;
  logic adv;
  logic uf;

  assign cnt_wr = bus_we && (int'(bus_addr) < NB);
  assign out_wr = bus_we && (int'(bus_addr) == 2 * NB + 1);
  assign adv    = tick && run && !cnt_wr;
  assign uf     = adv && (cnt == '0);

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt != '0) |=> (cnt == $past(cnt) - CW'(1))); // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (cnt == $past(rld))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run) && !cnt_wr) |=> $stable(cnt)); // R4
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && tog && !out_wr) |=> (out != $past(out))); // R5
  AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(uf && tog) && !out_wr) |=> $stable(out)); // R5
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> pend); // R6
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend); // R7
  AST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |=> (out == $past(wbit0))); // R10
endmodule

bind tmr_autoreload tmr_checker #(.NB(NB), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .wbit0    (bus_wdata[0]),
  .cnt      (cnt_q),
  .rld      (rld_q),
  .run      (run_q),
  .tog      (tog_q),
  .pend     (pend_q),
  .out      (tmr_out),
  .irq      (irq)
);

// File: tb/tb_tmr_autoreload.sv
`timescale 1ns/1ps
module tb_tmr_autoreload;
  localparam int NB = 2;
  localparam int DW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          tmr_out;
  logic          irq;

  always #2.5 clk = ~clk;

  tmr_autoreload #(.NB(NB), .DW(DW), .AW(AW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_out   (tmr_out),
    .irq       (irq)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] m_cnt = '0;
  logic [15:0] m_rld = '0;
  logic m_run = 0, m_tog = 0, m_ie = 0, m_pend = 0, m_out = 0;

  typedef struct { logic out; logic irq; } exp_t;
  exp_t q[$];

  function automatic logic [7:0] m_rd(input int a);
    case (a)
      0: return m_cnt[7:0];
      1: return m_cnt[15:8];
      2: return m_rld[7:0];
      3: return m_rld[15:8];
      4: return {m_pend, m_ie, m_tog, m_run, 4'b0000};
      5: return {7'b0, m_out};
      default: return 8'h00;
    endcase
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic step(input logic we, input int a, input logic [7:0] d, input logic tk);
    logic cw, uf;
    logic [15:0] nc;
    @(negedge clk);
    bus_we = we; bus_addr = AW'(a); bus_wdata = d; tick = tk;
    cw = we && (a < 2);
    uf = tk && m_run && !cw && (m_cnt == 16'h0);
    nc = m_cnt;
    if (tk && m_run && !cw) nc = (m_cnt == 16'h0) ? m_rld : m_cnt - 16'd1;
    if (we && a == 0) nc[7:0]  = d;
    if (we && a == 1) nc[15:8] = d;
    if (we && a == 5)           m_out = d[0];
    else if (uf && m_tog)       m_out = ~m_out;
    if (uf)                     m_pend = 1'b1;
    else if (we && a == 4 && d[7]) m_pend = 1'b0;
    if (we && a == 4) begin m_run = d[4]; m_tog = d[5]; m_ie = d[6]; end
    if (we && a == 2) m_rld[7:0]  = d;
    if (we && a == 3) m_rld[15:8] = d;
    m_cnt = nc;
    @(posedge clk);
    q.push_back('{m_out, m_pend & m_ie});
    #1;
    bus_we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_check(input int a, input logic [7:0] exp, input string tag);
    @(posedge clk);
    #1;
    bus_addr = AW'(a);
    #0.5;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d actual %02h expected %02h", tag, a, bus_rdata, exp);
    end
  endtask

  // Monitor: compares outputs one edge after each queued stimulus.
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (tmr_out !== e.out) begin
        errors++;
        $display("FAIL R5/R10 tmr_out actual %b expected %b", tmr_out, e.out);
      end
      checks++;
      if (irq !== e.irq) begin
        errors++;
        $display("FAIL R7 irq actual %b expected %b", irq, e.irq);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and R8 map
    for (int a = 0; a < 6; a++) rd_check(a, 8'h00, "R1");
    checks++;
    if (tmr_out !== 1'b0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1 out/irq actual %b%b expected 00", tmr_out, irq);
    end
    rd_check(6, 8'h00, "R8");

    // Period 4: reload 3, counter 2, run+toggle+ie
    step(1, 2, 8'h03, 0);
    step(1, 0, 8'h02, 0);
    step(1, 4, 8'h70, 0);
    rd_check(2, m_rd(2), "R8");
    rd_check(4, m_rd(4), "R8");
    for (int i = 0; i < 13; i++) step(0, 0, 8'h00, 1);
    rd_check(0, m_rd(0), "R3");
    rd_check(4, m_rd(4), "R6");

    // R2 tick low holds
    for (int i = 0; i < 4; i++) step(0, 0, 8'h00, 0);
    rd_check(0, m_rd(0), "R2");
    step(0, 0, 8'h00, 1);
    rd_check(0, m_rd(0), "R2");

    // R6 clear by writing 1, write 0 leaves alone
    step(1, 4, 8'hF0, 0);
    rd_check(4, m_rd(4), "R6");
    for (int i = 0; i < 5; i++) step(0, 0, 8'h00, 1);
    step(1, 4, 8'h70, 0);
    rd_check(4, m_rd(4), "R6");

    // R6 set wins over clear in the same cycle
    step(1, 0, 8'h00, 0);
    step(1, 1, 8'h00, 0);
    step(1, 4, 8'hF0, 1);
    rd_check(4, m_rd(4), "R6");

    // R7 interrupt enable off masks irq
    step(1, 4, 8'h30, 0);
    rd_check(4, m_rd(4), "R7");

    // R4 run clear holds counter
    step(1, 4, 8'h20, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 8'h00, 1);
    rd_check(0, m_rd(0), "R4");
    rd_check(1, m_rd(1), "R4");

    // R3 reload 0: underflow every tick, toggle every tick
    step(1, 2, 8'h00, 0);
    step(1, 3, 8'h00, 0);
    step(1, 0, 8'h00, 0);
    step(1, 4, 8'h70, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 8'h00, 1);
    rd_check(5, m_rd(5), "R3");

    // R5 toggle disabled
    step(1, 4, 8'h50, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 8'h00, 1);
    rd_check(5, m_rd(5), "R5");

    // R3 full range reload 0xFFFF
    step(1, 2, 8'hFF, 0);
    step(1, 3, 8'hFF, 0);
    step(1, 0, 8'h00, 0);
    step(0, 0, 8'h00, 1);
    rd_check(1, 8'hFF, "R3");
    rd_check(0, 8'hFF, "R3");
    step(0, 0, 8'h00, 1);
    rd_check(0, 8'hFE, "R3");

    // R9 counter write overrides the decrement
    step(1, 0, 8'h55, 1);
    rd_check(0, 8'h55, "R9");
    rd_check(1, 8'hFF, "R9");
    step(1, 0, 8'h00, 0);
    step(1, 1, 8'h00, 0);
    step(1, 4, 8'h70, 0);
    step(1, 1, 8'h00, 1);
    rd_check(0, 8'h00, "R9");
    rd_check(4, m_rd(4), "R9");

    // R10 preset output, and preset beats a toggle
    step(1, 5, 8'h01, 0);
    rd_check(5, 8'h01, "R10");
    step(1, 5, 8'h01, 1);
    rd_check(5, 8'h01, "R10");
    rd_check(0, m_rd(0), "R10");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule